// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a slave on a three-wire serial bus. The three lines are a serial clock, a bidirectional data line and an active-high enable. A transfer begins when the enable goes high. The first byte shifted in is a subaddress. Bit 7 of that byte chooses the direction: 0 for write and 1 for read. The other seven bits point into the address space.

On a write, each later byte goes into a configuration register bank, and the subaddress then moves on by one. On a read, the block takes a snapshot of its status inputs when the subaddress byte completes. It then shifts bytes out from that snapshot.

The status readout holds two 7-bit converter results and two frequency-window flags, packed into a pair of bytes. The threshold register splits into two nibbles that go straight to the core logic. All serial lines are oversampled in the system clock domain. The master must therefore hold each serial clock phase for several system clocks.

Top module: `tw_serial_regs`

## Requirements
- R1: While reset is held, and after it is released, every configuration output reads zero, `sdo_oe_o` is low and `sdo_o` is low.
- R2: A subaddress byte with bit 7 = 0 starts a write. Each later byte is sampled MSB first on rising serial clock edges. It is stored at index addr[6:0] and appears on `cfg_o[8*idx +: 8]`.
- R3: After every data byte of a write, the subaddress advances by one, so one frame can fill several consecutive registers.
- R4: A write to index NREG or above changes no configuration output.
- R5: If enable falls before the eighth bit of a byte, nothing is written. The next frame starts again with a subaddress byte.
- R6: A subaddress byte with bit 7 = 1 starts a read. Read bits are driven MSB first, and each one changes only after a falling serial clock edge. `sdo_oe_o` stays high for the whole read phase.
- R7: Read subaddress 0x82 returns {win_hit_i, adc1_i}. Subaddress 0x83, reached by auto-increment, returns {win_low_i, adc2_i}. Every other read subaddress returns 0x00.
- R8: The status inputs are captured when the read subaddress byte completes. Changes to them during the rest of the frame are not returned.
- R9: Register index 0x0B carries the two thresholds. `thr1_o` is bits 7:4 and `thr2_o` is bits 3:0.
- R10: When enable is low, `sdo_oe_o` goes low within the synchroniser latency.

Top module is as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from the master |
| sen_i | input | 1 | Frame enable, active high |
| sdo_o | output | 1 | Serial data to the master |
| sdo_oe_o | output | 1 | Drive enable for the data line |
| cfg_o | output | NREG*8 | Flattened configuration registers |
| thr1_o | output | 4 | Channel 1 threshold |
| thr2_o | output | 4 | Channel 2 threshold |
| adc1_i | input | 7 | Channel 1 converter result |
| adc2_i | input | 7 | Channel 2 converter result |
| win_hit_i | input | 1 | Frequency-in-window flag |
| win_low_i | input | 1 | Frequency-too-low flag |

## Verification
The bench aborts a frame after five bits of a data byte. A design that commits partial bytes, or that keeps its bit count across frames, would corrupt a register or misread the next subaddress. It changes the status inputs between the subaddress and the data phase. A design without a snapshot would return the new values, or a mix of old and new.

Multi-byte writes run past the register bank. An address that wraps or aliases would overwrite low registers. Reads cover the 0x82/0x83 pair and an unused address, sampling on each rising edge. A design that drives on the wrong edge, or that shifts LSB first, would return wrong bytes.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WRITE, PH_READ} phase_e;
  localparam logic [7:0] STAT_ADDR = 8'h82;
  localparam int THR_IDX = 11;
  localparam int ADC_W = 7;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;
  logic [N-1:0] chain_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) chain_q[k] <= '0;
    end else begin
      chain_q[0] <= pin_i;
      for (int k = 1; k < DEPTH; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign lvl_o = chain_q[STAGES-1];

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise_o[g] = chain_q[STAGES-1][g] & ~chain_q[STAGES][g];
    assign fall_o[g] = ~chain_q[STAGES-1][g] & chain_q[STAGES][g];
  end
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_lvl,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       sdi_lvl,
  input  logic [7:0] rd_byte_i,
  output logic [7:0] addr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  output logic       snap_ld_o,
  output logic       sdo_o,
  output logic       oe_o
);
  phase_e     phase_q, phase_d, eff;
  logic [7:0] sh_q, sh_d, addr_q, addr_d, byte_in;
  logic [2:0] bcnt_q, bcnt_d;
  logic       sdo_q, sdo_d;

  function automatic logic [7:0] next_addr(input logic [7:0] a);
    return {a[7], a[6:0] + 7'd1};
  endfunction

  always_comb begin
    eff       = (phase_q == PH_IDLE) ? PH_ADDR : phase_q;
    phase_d   = eff;
    sh_d      = sh_q;
    addr_d    = addr_q;
    bcnt_d    = bcnt_q;
    sdo_d     = sdo_q;
    wr_stb_o  = 1'b0;
    snap_ld_o = 1'b0;
    byte_in   = {sh_q[6:0], sdi_lvl};
    if (!en_lvl) begin
      phase_d = PH_IDLE;
      bcnt_d  = '0;
    end else if (sclk_rise && eff != PH_READ) begin
      sh_d   = byte_in;
      bcnt_d = bcnt_q + 3'd1;
      if (bcnt_q == 3'd7) begin
        if (eff == PH_ADDR) begin
          addr_d    = byte_in;
          snap_ld_o = 1'b1;
          phase_d   = byte_in[7] ? PH_READ : PH_WRITE;
        end else begin
          wr_stb_o = 1'b1;
          addr_d   = next_addr(addr_q);
        end
      end
    end else if (sclk_fall && eff == PH_READ) begin
      sdo_d  = rd_byte_i[~bcnt_q];
      bcnt_d = bcnt_q + 3'd1;
      if (bcnt_q == 3'd7) addr_d = next_addr(addr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      addr_q  <= '0;
      bcnt_q  <= '0;
      sdo_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      bcnt_q  <= bcnt_d;
      sdo_q   <= sdo_d;
    end
  end

  assign addr_o    = addr_q;
  assign wr_data_o = byte_in;
  assign sdo_o     = sdo_q;
  assign oe_o      = (phase_q == PH_READ);
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic [NREG*8-1:0] cfg_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] val_q;
    logic       hit;
    assign hit = wr_stb && (wr_addr[6:0] == 7'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wr_data;
    end
    assign cfg_o[8*g +: 8] = val_q;
  end
endmodule

// File: rtl/tw_stat.sv
module tw_stat
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_ld,
  input  logic [ADC_W-1:0] adc1_i,
  input  logic [ADC_W-1:0] adc2_i,
  input  logic             hit_i,
  input  logic             low_i,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_byte_o
);
  logic [7:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (snap_ld) begin
      lo_q <= {hit_i, adc1_i};
      hi_q <= {low_i, adc2_i};
    end
  end

  always_comb begin
    if (rd_addr == STAT_ADDR)              rd_byte_o = lo_q;
    else if (rd_addr == STAT_ADDR + 8'd1)  rd_byte_o = hi_q;
    else                                   rd_byte_o = '0;
  end
endmodule

// File: rtl/tw_serial_regs.sv
module tw_serial_regs
  import tw_pkg::*;
#(
  parameter int NREG = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             sen_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic [3:0]       thr1_o,
  output logic [3:0]       thr2_o,
  input  logic [ADC_W-1:0] adc1_i,
  input  logic [ADC_W-1:0] adc2_i,
  input  logic             win_hit_i,
  input  logic             win_low_i
);
  logic [1:0] rst_q;
  logic       rst_s_n;
  logic [2:0] lvl, rise, fall;
  logic       en_lvl, sclk_fall;
  logic [7:0] addr, wr_data, rd_byte;
  logic       wr_stb, snap_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  tw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .pin_i({sen_i, sdi_i, sclk_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );
  assign en_lvl    = lvl[2];
  assign sclk_fall = fall[0];

  tw_frame u_frame (
    .clk(clk), .rst_n(rst_s_n), .en_lvl(en_lvl), .sclk_rise(rise[0]),
    .sclk_fall(sclk_fall), .sdi_lvl(lvl[1]), .rd_byte_i(rd_byte),
    .addr_o(addr), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .snap_ld_o(snap_ld), .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  tw_regbank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_s_n), .wr_stb(wr_stb), .wr_addr(addr),
    .wr_data(wr_data), .cfg_o(cfg_o)
  );

  tw_stat u_stat (
    .clk(clk), .rst_n(rst_s_n), .snap_ld(snap_ld), .adc1_i(adc1_i),
    .adc2_i(adc2_i), .hit_i(win_hit_i), .low_i(win_low_i),
    .rd_addr(addr), .rd_byte_o(rd_byte)
  );

  if (THR_IDX < NREG) begin : g_thr
    assign thr1_o = cfg_o[8*THR_IDX+4 +: 4];
    assign thr2_o = cfg_o[8*THR_IDX +: 4];
  end else begin : g_nothr
    assign thr1_o = '0;
    assign thr2_o = '0;
  end
endmodule

// File: rtl/tw_serial_regs_chk.sv
module tw_serial_regs_chk #(
  parameter int NREG = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_lvl,
  input logic             sclk_fall,
  input logic             wr_stb,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic [NREG*8-1:0] cfg_o
);
  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lvl |=> !sdo_oe_o);

  // R2
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(wr_stb));

  // R6
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sclk_fall));

  // R5
  wr_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (en_lvl && !sdo_oe_o));
endmodule

bind tw_serial_regs tw_serial_regs_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_lvl(en_lvl), .sclk_fall(sclk_fall),
  .wr_stb(wr_stb), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .cfg_o(cfg_o)
);

// File: tb/sim_tw_serial_regs.sv
`timescale 1ns/1ps
module sim_tw_serial_regs;
  localparam int NREG = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, sen = 1'b0;
  logic sdo, sdo_oe;
  logic [NREG*8-1:0] cfg;
  logic [3:0] thr1, thr2;
  logic [6:0] adc1 = '0, adc2 = '0;
  logic hit = 1'b0, low = 1'b0;

  int errors = 0;
  int checks = 0;
  bit busy = 1'b0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  tw_serial_regs #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sen_i(sen),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg), .thr1_o(thr1), .thr2_o(thr2),
    .adc1_i(adc1), .adc2_i(adc2), .win_hit_i(hit), .win_low_i(low)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Clock-by-clock comparison of the register bank and threshold outputs (R2, R3, R4, R9)
  always @(negedge clk) begin
    if (rst_n && !busy && !done) begin
      logic [NREG*8-1:0] expv;
      for (int n = 0; n < NREG; n++) expv[8*n +: 8] = model[n];
      check(cfg === expv, "R2", cfg[31:0], expv[31:0]);
      check(thr1 === model[11][7:4] && thr2 === model[11][3:0], "R9",
            {thr1, thr2}, model[11]);
    end
  end

  task automatic frame_start();
    sen = 1'b1;
    tick(HALF);
  endtask

  task automatic frame_stop();
    tick(HALF);
    sen = 1'b0;
    tick(2 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit mark);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      tick(HALF);
      sclk = 1'b1;
      if (i == 0 && mark) busy = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic write_frame(input logic [6:0] a, input logic [7:0] d[$]);
    int idx = a;
    frame_start();
    send_bits({1'b0, a}, 8, 1'b0);
    foreach (d[k]) begin
      send_bits(d[k], 8, 1'b1);
      if (idx < NREG) model[idx] = d[k];
      idx = (idx + 1) % 128;
      busy = 1'b0;
    end
    frame_stop();
  endtask

  task automatic read_byte(output logic [7:0] got, input string req);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      got[i] = sdo;
      if (i == 7) check(sdo_oe === 1'b1, "R6", {31'd0, sdo_oe}, 32'd1);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] q[$];
    for (int n = 0; n < NREG; n++) model[n] = 8'h00;
    tick(4);
    // R1: outputs while reset is held
    check(cfg === '0, "R1", cfg[31:0], 0);
    check(sdo_oe === 1'b0 && sdo === 1'b0, "R1", {sdo_oe, sdo}, 0);
    rst_n = 1'b1;
    tick(6);
    check(cfg === '0 && sdo_oe === 1'b0, "R1", cfg[31:0], 0);

    // R2: single-byte write
    q = {8'hA5};
    write_frame(7'h03, q);
    check(cfg[8*3 +: 8] === 8'hA5, "R2", cfg[8*3 +: 8], 8'hA5);

    // R3, R9: auto-increment across the threshold register
    q = {8'h11, 8'h7C, 8'h3E};
    write_frame(7'h0A, q);
    check(cfg[8*12 +: 8] === 8'h3E, "R3", cfg[8*12 +: 8], 8'h3E);
    check(thr1 === 4'h7 && thr2 === 4'hC, "R9", {thr1, thr2}, 8'h7C);

    // R4: run past the bank, then write out of range directly
    q = {8'hE1, 8'hF0};
    write_frame(7'h0F, q);
    q = {8'h5A};
    write_frame(7'h7F, q);
    check(cfg[7:0] === 8'h00 && cfg[8*15 +: 8] === 8'hE1, "R4",
          {cfg[8*15 +: 8], cfg[7:0]}, 16'hE100);

    // R5: abort after five bits of the second data byte
    frame_start();
    send_bits(8'h05, 8, 1'b0);
    send_bits(8'h99, 8, 1'b1);
    model[5] = 8'h99;
    busy = 1'b0;
    send_bits(8'h66, 5, 1'b0);
    frame_stop();
    check(cfg[8*6 +: 8] === 8'h00, "R5", cfg[8*6 +: 8], 0);
    q = {8'h42};
    write_frame(7'h01, q);
    check(cfg[8*1 +: 8] === 8'h42, "R5", cfg[8*1 +: 8], 8'h42);

    // R7: status pair and the byte after it
    adc1 = 7'h55; adc2 = 7'h2A; hit = 1'b1; low = 1'b0;
    frame_start();
    send_bits(8'h82, 8, 1'b0);
    read_byte(got, "R7");
    check(got === 8'hD5, "R7", got, 8'hD5);
    read_byte(got, "R7");
    check(got === 8'h2A, "R7", got, 8'h2A);
    read_byte(got, "R7");
    check(got === 8'h00, "R7", got, 0);
    frame_stop();
    // R10: drive enable drops once the frame ends
    check(sdo_oe === 1'b0, "R10", {31'd0, sdo_oe}, 0);

    // R8: inputs change after the subaddress byte
    adc1 = 7'h0F; adc2 = 7'h70; hit = 1'b0; low = 1'b1;
    frame_start();
    send_bits(8'h82, 8, 1'b0);
    adc1 = 7'h7F; adc2 = 7'h01; hit = 1'b1; low = 1'b0;
    read_byte(got, "R8");
    check(got === 8'h0F, "R8", got, 8'h0F);
    read_byte(got, "R8");
    check(got === 8'hF0, "R8", got, 8'hF0);
    frame_stop();

    // R7: unused read address
    frame_start();
    send_bits(8'h90, 8, 1'b0);
    read_byte(got, "R7");
    check(got === 8'h00, "R7", got, 0);
    frame_stop();
    check(sdo_oe === 1'b0, "R10", {31'd0, sdo_oe}, 0);

    tick(10);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule